// File: doc/BRIEF.md
# I2C Master Acknowledge and Stop Sequencer

This block is the tail end of an I2C master: once a byte has moved across the bus, it drives either the acknowledge bit (ACK or NACK) or a stop condition. Both lines are open-drain. The block only pulls them low through drive-enable outputs and reads the real line levels back through a two-flop synchronizer. Each bus phase is timed by a reloadable down-counter. The counter starts a phase only when the line reads back at the level the block is driving, so a slave that holds SCL low stretches the clock without shortening the high time.

Software-facing control is a set of plain strobes and level bits: an acknowledge request, a stop request, the acknowledge data bit, a data-buffer write, and clear strobes for the two sticky flags. There is no data stream at the edge. The buffer write is a single-cycle strobe with no ready signal, and a write that cannot be taken is dropped and flagged rather than held back. Status outputs report busy, a completion interrupt flag, stop detection and write collisions.

Top module: `i2c_ackstop_seq`

## Requirements
- R1: An acknowledge request accepted in idle makes SCL drive low and SDA drive equal to the inverse of the ack bit on the next cycle. Ack bit 0 drives SDA low (ACK); ack bit 1 releases SDA (NACK). The bit is captured when the request is accepted.
- R2: Each phase lasts reload+4 clocks, counted from the cycle its line first reads back at the driven level: two synchronizer stages, one load cycle, and reload+1 count cycles. For the acknowledge, this is the SCL high time.
- R3: A slave holding SCL low after release delays the phase without shortening it. Every stretched cycle is spent with SCL released and reading low, and the high time stays reload+4 clocks.
- R4: At the end of an acknowledge, SCL is driven low again and SDA is released, busy falls, and the interrupt flag sets. SCL stays driven low in idle, and SDA is never driven while idle.
- R5: An accepted stop request drives SDA low and holds SCL low on the next cycle. SCL is released one phase after SDA reads low. SCL then reads high with SDA still low for reload+4 clocks before SDA is released.
- R6: When both lines read high, stop-detected sets. Busy falls and the interrupt flag sets reload+4 clocks after SDA rises. Stop-detected clears when the next request is accepted.
- R7: A buffer write while busy, or in the same cycle a request is accepted, sets the write-collision flag and leaves the buffer unchanged. An idle write updates the buffer on the next cycle and leaves the flag alone.
- R8: The interrupt and write-collision flags hold until their clear strobe. A set and a clear in the same cycle leave the flag set.
- R9: A request that arrives while busy is ignored.
- R10: Simultaneous acknowledge and stop requests in idle start the acknowledge.
- R11: After reset, both lines are released, busy and all flags are 0, and the buffer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ack_start | input | 1 | Request an acknowledge sequence |
| stop_start | input | 1 | Request a stop sequence |
| ack_data | input | 1 | Acknowledge bit, 0 = ACK, 1 = NACK |
| reload | input | RW (7) | Baud reload; one period = reload+1 clocks |
| buf_wr | input | 1 | Data-buffer write strobe |
| buf_wdata | input | DW (8) | Data-buffer write value |
| scl_in | input | 1 | SCL line level read back |
| sda_in | input | 1 | SDA line level read back |
| scl_low_en | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_low_en | output | 1 | 1 pulls SDA low, 0 releases it |
| busy | output | 1 | A sequence is in progress |
| irq_flag | output | 1 | Sticky sequence-complete flag |
| irq_clr | input | 1 | Clears irq_flag |
| stop_seen | output | 1 | Stop condition detected on the bus |
| wcol | output | 1 | Sticky write-collision flag |
| wcol_clr | input | 1 | Clears wcol |
| buf_q | output | DW (8) | Data-buffer contents |

## Verification
Two events can land on the same clock edge. The first is a buffer write arriving on the cycle a request is accepted, while busy still reads 0. The bench drives both strobes on one cycle and expects a collision with the buffer unchanged. The second is the completion edge that sets the interrupt flag while its clear strobe is active. The bench holds irq_clr high through a whole acknowledge, drops it on the first cycle busy reads low, and expects the flag to be set.

// File: rtl/ackstop_pkg.sv
package ackstop_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_ACK_LOW,
    S_ACK_HIGH,
    S_STP_SDA,
    S_STP_SCL,
    S_STP_REL
  } seq_state_e;
endpackage

// File: rtl/ackstop_sync.sv
// Multi-stage synchronizer for the read-back line levels; resets to bus-idle high.
module ackstop_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
    end else begin
      chain_q[0] <= d;
      for (int s = 1; s < STAGES; s++) begin
        chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign q = chain_q[LAST];
endmodule

// File: rtl/ackstop_baud.sv
// Reloadable down-counter: arms on the first cycle run_ok is seen, counts only
// while run_ok holds, expires after reload+1 counting cycles.
module ackstop_baud #(
  parameter int RW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] reload,
  input  logic          run_ok,
  output logic          load_pulse,
  output logic          expired
);
  logic          armed_q;
  logic [RW-1:0] cnt_q;

  assign load_pulse = !armed_q && run_ok;
  assign expired    = armed_q && run_ok && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (expired) begin
      armed_q <= 1'b0;
    end else if (load_pulse) begin
      armed_q <= 1'b1;
      cnt_q   <= reload;
    end else if (armed_q && run_ok) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/ackstop_fsm.sv
module ackstop_fsm
  import ackstop_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ack_req,
  input  logic stop_req,
  input  logic ack_bit,
  input  logic scl_s,
  input  logic sda_s,
  input  logic tmr_load,
  input  logic tmr_done,
  output logic run_ok,
  output logic scl_low,
  output logic sda_low,
  output logic busy,
  output logic accept,
  output logic seq_done,
  output logic stop_hit
);
  seq_state_e st_q;

  // Each phase counts only while its line reads back at the driven level.
  always_comb begin
    unique case (st_q)
      S_ACK_LOW:  run_ok = !scl_s;
      S_ACK_HIGH: run_ok = scl_s;
      S_STP_SDA:  run_ok = !sda_s;
      S_STP_SCL:  run_ok = scl_s;
      S_STP_REL:  run_ok = scl_s && sda_s;
      default:    run_ok = 1'b0;
    endcase
  end

  assign busy     = (st_q != S_IDLE);
  assign accept   = !busy && (ack_req || stop_req);
  assign seq_done = tmr_done && ((st_q == S_ACK_HIGH) || (st_q == S_STP_REL));
  assign stop_hit = tmr_load && (st_q == S_STP_REL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      scl_low <= 1'b0;
      sda_low <= 1'b0;
    end else begin
      unique case (st_q)
        S_IDLE: begin
          if (ack_req) begin
            st_q    <= S_ACK_LOW;
            scl_low <= 1'b1;
            sda_low <= !ack_bit;
          end else if (stop_req) begin
            st_q    <= S_STP_SDA;
            scl_low <= 1'b1;
            sda_low <= 1'b1;
          end
        end
        S_ACK_LOW: if (tmr_done) begin
          st_q    <= S_ACK_HIGH;
          scl_low <= 1'b0;
        end
        S_ACK_HIGH: if (tmr_done) begin
          st_q    <= S_IDLE;
          scl_low <= 1'b1;
          sda_low <= 1'b0;
        end
        S_STP_SDA: if (tmr_done) begin
          st_q    <= S_STP_SCL;
          scl_low <= 1'b0;
        end
        S_STP_SCL: if (tmr_done) begin
          st_q    <= S_STP_REL;
          sda_low <= 1'b0;
        end
        S_STP_REL: if (tmr_done) begin
          st_q <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ackstop_flags.sv
module ackstop_flags #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic          accept,
  input  logic          seq_done,
  input  logic          stop_hit,
  input  logic          irq_clr,
  input  logic          wcol_clr,
  input  logic          buf_wr,
  input  logic [DW-1:0] buf_wdata,
  output logic          irq_flag,
  output logic          wcol,
  output logic          stop_seen,
  output logic [DW-1:0] buf_q
);
  logic wr_blocked;
  assign wr_blocked = busy || accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_flag  <= 1'b0;
      wcol      <= 1'b0;
      stop_seen <= 1'b0;
      buf_q     <= '0;
    end else begin
      if (seq_done)     irq_flag <= 1'b1;
      else if (irq_clr) irq_flag <= 1'b0;

      if (buf_wr && wr_blocked) wcol <= 1'b1;
      else if (wcol_clr)        wcol <= 1'b0;

      if (accept)        stop_seen <= 1'b0;
      else if (stop_hit) stop_seen <= 1'b1;

      if (buf_wr && !wr_blocked) buf_q <= buf_wdata;
    end
  end
endmodule

// File: rtl/i2c_ackstop_seq.sv
module i2c_ackstop_seq #(
  parameter int RW          = 7,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ack_start,
  input  logic          stop_start,
  input  logic          ack_data,
  input  logic [RW-1:0] reload,
  input  logic          buf_wr,
  input  logic [DW-1:0] buf_wdata,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          scl_low_en,
  output logic          sda_low_en,
  output logic          busy,
  output logic          irq_flag,
  input  logic          irq_clr,
  output logic          stop_seen,
  output logic          wcol,
  input  logic          wcol_clr,
  output logic [DW-1:0] buf_q
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] line_s;
  logic run_ok, tmr_load, tmr_done, accept, seq_done, stop_hit;

  ackstop_sync #(.WIDTH(NLINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sda_in, scl_in}), .q(line_s)
  );

  ackstop_baud #(.RW(RW)) u_baud (
    .clk(clk), .rst_n(rst_n), .reload(reload), .run_ok(run_ok),
    .load_pulse(tmr_load), .expired(tmr_done)
  );

  ackstop_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .ack_req(ack_start), .stop_req(stop_start),
    .ack_bit(ack_data), .scl_s(line_s[0]), .sda_s(line_s[1]),
    .tmr_load(tmr_load), .tmr_done(tmr_done), .run_ok(run_ok),
    .scl_low(scl_low_en), .sda_low(sda_low_en), .busy(busy),
    .accept(accept), .seq_done(seq_done), .stop_hit(stop_hit)
  );

  ackstop_flags #(.DW(DW)) u_flags (
    .clk(clk), .rst_n(rst_n), .busy(busy), .accept(accept),
    .seq_done(seq_done), .stop_hit(stop_hit), .irq_clr(irq_clr),
    .wcol_clr(wcol_clr), .buf_wr(buf_wr), .buf_wdata(buf_wdata),
    .irq_flag(irq_flag), .wcol(wcol), .stop_seen(stop_seen), .buf_q(buf_q)
  );
endmodule

// File: rtl/ackstop_checker.sv
module ackstop_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ack_start,
  input logic          stop_start,
  input logic          ack_data,
  input logic          buf_wr,
  input logic          scl_low_en,
  input logic          sda_low_en,
  input logic          busy,
  input logic          irq_flag,
  input logic          irq_clr,
  input logic          stop_seen,
  input logic          wcol,
  input logic [DW-1:0] buf_q
);
  p_ack_drive_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_start && !busy) |=> (scl_low_en && (sda_low_en == !$past(ack_data))));

  p_idle_sda_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sda_low_en);

  p_done_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> irq_flag);

  p_stop_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_start && !ack_start && !busy) |=> (sda_low_en && scl_low_en));

  p_stop_lines_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_seen) |-> (!sda_low_en && !scl_low_en));

  p_wcol_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_wr && busy) |=> wcol);

  p_buf_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_wr && busy) |=> $stable(buf_q));

  p_irq_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !irq_clr) |=> irq_flag);

  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && stop_start && scl_low_en && !sda_low_en) |=> !sda_low_en || busy);
endmodule

bind i2c_ackstop_seq ackstop_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack_start(ack_start), .stop_start(stop_start),
  .ack_data(ack_data), .buf_wr(buf_wr), .scl_low_en(scl_low_en),
  .sda_low_en(sda_low_en), .busy(busy), .irq_flag(irq_flag),
  .irq_clr(irq_clr), .stop_seen(stop_seen), .wcol(wcol), .buf_q(buf_q)
);

// File: tb/tb_i2c_ackstop_seq.sv
module tb_i2c_ackstop_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ack_start = 0, stop_start = 0, ack_data = 0;
  logic [6:0] reload = '0;
  logic buf_wr = 0;
  logic [7:0] buf_wdata = '0;
  logic irq_clr = 0, wcol_clr = 0;
  logic scl_low_en, sda_low_en, busy, irq_flag, stop_seen, wcol;
  logic [7:0] buf_q;
  logic scl_line, sda_line;
  int   hold = 0;
  int   stretch_cfg = 0;
  int   n_cmp = 0, n_bad = 0;

  always #10 clk = ~clk;

  assign scl_line = !(scl_low_en || (hold != 0));
  assign sda_line = !sda_low_en;

  i2c_ackstop_seq dut (
    .clk(clk), .rst_n(rst_n), .ack_start(ack_start), .stop_start(stop_start),
    .ack_data(ack_data), .reload(reload), .buf_wr(buf_wr), .buf_wdata(buf_wdata),
    .scl_in(scl_line), .sda_in(sda_line), .scl_low_en(scl_low_en),
    .sda_low_en(sda_low_en), .busy(busy), .irq_flag(irq_flag), .irq_clr(irq_clr),
    .stop_seen(stop_seen), .wcol(wcol), .wcol_clr(wcol_clr), .buf_q(buf_q)
  );

  // Slave model: holds SCL low for a while after the master releases it.
  initial forever begin
    @(posedge clk); #1;
    if (scl_low_en) hold = stretch_cfg;
    else if (hold != 0) hold = hold - 1;
  end

  typedef struct packed {
    logic       is_stop;
    logic [6:0] rld;
    logic       ackd;
    logic [3:0] strc;
    logic [7:0] exp_hi;
    logic [3:0] exp_str;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 7'd3, 1'b0, 4'd0, 8'd7,  4'd0},
    '{1'b0, 7'd5, 1'b1, 4'd0, 8'd9,  4'd0},
    '{1'b0, 7'd2, 1'b0, 4'd6, 8'd6,  4'd5},
    '{1'b1, 7'd4, 1'b0, 4'd0, 8'd8,  4'd0},
    '{1'b0, 7'd0, 1'b1, 4'd3, 8'd4,  4'd2},
    '{1'b1, 7'd7, 1'b0, 4'd0, 8'd11, 4'd0},
    '{1'b1, 7'd0, 1'b0, 4'd4, 8'd4,  4'd3}
  };

  task automatic chk(input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic wait_idle();
    for (int g = 0; g < 5000 && busy; g++) @(negedge clk);
  endtask

  task automatic run_vec(input vec_t v);
    int hi = 0, hi2 = 0, st = 0, sda_hi = -1;
    reload = v.rld; ack_data = v.ackd; stretch_cfg = int'(v.strc);
    @(negedge clk);
    if (v.is_stop) stop_start = 1; else ack_start = 1;
    @(negedge clk);
    ack_start = 0; stop_start = 0;
    if (v.is_stop) begin
      chk("R5 stop start SDA drive", sda_low_en, 1);
      chk("R5 stop start SCL drive", scl_low_en, 1);
    end else begin
      chk("R1 ack start SCL drive", scl_low_en, 1);
      chk("R1 ack start SDA drive", sda_low_en, !v.ackd);
    end
    for (int g = 0; g < 5000 && busy; g++) begin
      if (!scl_low_en && !scl_line) st++;
      if (v.is_stop) begin
        if (scl_line && !sda_line) hi++;
        if (scl_line && sda_line) hi2++;
      end else if (scl_line) begin
        hi++;
        if (sda_hi < 0) sda_hi = sda_line;
      end
      @(negedge clk);
    end
    chk("R3 stretched cycles", st, int'(v.exp_str));
    if (v.is_stop) begin
      chk("R5 SCL high with SDA low", hi, int'(v.exp_hi));
      chk("R6 SDA high until done", hi2, int'(v.exp_hi));
      chk("R6 stop_seen set", stop_seen, 1);
      chk("R6 lines released", scl_low_en | sda_low_en, 0);
    end else begin
      chk("R2 ack SCL high width", hi, int'(v.exp_hi));
      chk("R1 SDA level during ack", sda_hi, v.ackd);
      chk("R4 SCL driven low at end", scl_low_en, 1);
      chk("R4 SDA released at end", sda_low_en, 0);
    end
    chk("R4 irq set at end", irq_flag, 1);
    irq_clr = 1;
    @(negedge clk);
    irq_clr = 0;
    chk("R8 irq cleared by strobe", irq_flag, 0);
    stretch_cfg = 0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(negedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk("R11 SCL released", scl_low_en, 0);
    chk("R11 SDA released", sda_low_en, 0);
    chk("R11 busy", busy, 0);
    chk("R11 irq", irq_flag, 0);
    chk("R11 wcol", wcol, 0);
    chk("R11 stop_seen", stop_seen, 0);
    chk("R11 buffer", buf_q, 0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R6 stop_seen cleared by next accepted request
    reload = 7'd1; ack_data = 0;
    ack_start = 1;
    @(negedge clk);
    ack_start = 0;
    chk("R6 stop_seen cleared", stop_seen, 0);
    wait_idle();

    // R7 idle write accepted
    buf_wr = 1; buf_wdata = 8'hA5; wcol_clr = 1;
    @(negedge clk);
    buf_wr = 0; wcol_clr = 0;
    chk("R7 idle write stored", buf_q, 8'hA5);
    chk("R7 idle write no collision", wcol, 0);

    // R7 write while busy, R8 sticky and clear; R9 request while busy ignored
    ack_start = 1;
    @(negedge clk);
    ack_start = 0;
    buf_wr = 1; buf_wdata = 8'h3C;
    @(negedge clk);
    buf_wr = 0;
    chk("R7 busy write collision", wcol, 1);
    chk("R7 busy write dropped", buf_q, 8'hA5);
    stop_start = 1;
    @(negedge clk);
    stop_start = 0;
    wait_idle();
    repeat (10) @(negedge clk);
    chk("R8 wcol sticky", wcol, 1);
    chk("R9 stop ignored busy", busy, 0);
    chk("R9 stop ignored stop_seen", stop_seen, 0);
    chk("R9 stop ignored SCL held", scl_low_en, 1);
    wcol_clr = 1;
    @(negedge clk);
    wcol_clr = 0;
    chk("R8 wcol cleared", wcol, 0);
    irq_clr = 1;
    @(negedge clk);
    irq_clr = 0;

    // R7 write on the accept cycle
    ack_start = 1; buf_wr = 1; buf_wdata = 8'h77;
    @(negedge clk);
    ack_start = 0; buf_wr = 0;
    chk("R7 accept-cycle collision", wcol, 1);
    chk("R7 accept-cycle write dropped", buf_q, 8'hA5);
    wait_idle();

    // R8 set wins over clear on the completion edge
    irq_clr = 1;
    @(negedge clk);
    ack_start = 1;
    @(negedge clk);
    ack_start = 0;
    wait_idle();
    irq_clr = 0;
    chk("R8 set wins over clear", irq_flag, 1);
    irq_clr = 1;
    @(negedge clk);
    irq_clr = 0;

    // R10 simultaneous requests: ack wins (NACK keeps SDA released)
    ack_data = 1;
    ack_start = 1; stop_start = 1;
    @(negedge clk);
    ack_start = 0; stop_start = 0;
    chk("R10 ack priority SCL", scl_low_en, 1);
    chk("R10 ack priority SDA", sda_low_en, 0);
    wait_idle();
    chk("R10 no stop after ack", stop_seen, 0);
    chk("R10 SCL held after ack", scl_low_en, 1);

    summary();
    $finish;
  end
endmodule